// File: doc/BRIEF.md
# Aligned Bitmap Buffer Allocator

This block hands out and takes back regions of a 16 KiB shared buffer memory. The memory is divided into 64 blocks of 256 bytes. Occupancy is held in two 32-bit map words, one bit per block. An allocation request gives a byte size. The block converts the size into a whole number of blocks and picks an alignment step: the smallest power-of-two block count that covers the request. It then walks the aligned candidate positions in ascending order, one per clock, and claims the first run whose bits are all clear. It answers with the byte offset of that run. When nothing fits, it answers with 16384.

A release request gives an offset and a size. It clears the run that an allocation of that size at that offset would have set. Requests use a simple handshake. A request is taken while the block is idle. `busy` stays high while the request is worked on. A one-cycle `done` pulse presents the result on `result_offset`.

Top module: `blkmap_alloc`

## Requirements
- R1: After reset `busy` and `done` are low and every block is free, so the first allocation of any legal size returns offset 0.
- R2: An allocation marks ceil(size/256) blocks, not the alignment step; blocks beyond that count inside the step stay free for later requests.
- R3: The alignment step is the smallest of 1, 2, 4, 8, 16 or 32 blocks whose span is at least the size. Candidate positions are multiples of that step within a map word.
- R4: Candidates are visited from bit 0 of word 0 upward by the step. After the last candidate of a word the search moves to bit 0 of the next word. A run never spans two map words, so a 32-block request can only sit at bit 0 of a word.
- R5: A size of 0, a size above 8192 bytes, or a search that finds no free aligned run answers 16384.
- R6: A successful allocation answers (word*32 + bit)*256, where word and bit are those of the first block of the claimed run.
- R7: A release (`req_op` = 1) clears ceil(size/256) bits starting at block offset/256, in word (offset/256)/32 at bit (offset/256) mod 32. It answers the offset rounded down to a multiple of 256.
- R8: Releasing blocks that are already free changes no other bit of the map.
- R9: A request is taken when `req_valid` is high while `busy` is low (`req_op` = 0 allocates, 1 releases). `busy` is high from the next cycle until the result. `done` is high for exactly one cycle with `busy` low. Requests raised while busy are ignored.
- R10: Counted in rising edges after the accepting edge, `done` is seen after 1 edge for a release or a rejected size. It is seen after n+2 edges when candidate n (counted from 0) wins, and after N+1 edges when all N candidates fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_size | input | 16 | Request size in bytes |
| req_offset | input | 15 | Byte offset of the run to release |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| result_offset | output | 15 | Byte offset of the result, 16384 on failure |

## Verification
A corrupted map bit shows up at the next allocation whose search reaches that block. The returned offset moves to a later candidate, or to an earlier block that should have been taken. The `done` latency shifts by the same number of candidates, so the fault appears within one request. A wrong step or run length shows the same way, as a misplaced offset or a different candidate count on the following allocation. A handshake fault shows at once as a missing, doubled or early `done`.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORK = 2'd1,
    ST_SCAN = 2'd2
  } bm_state_e;

  localparam logic OP_ALLOC = 1'b0;
  localparam logic OP_FREE  = 1'b1;
endpackage

// File: rtl/blkmap_sizer.sv
// Converts a byte size into a block count, an alignment step and a legality flag.
module blkmap_sizer #(
  parameter int SIZE_W    = 16,
  parameter int BLK_SHIFT = 8,
  parameter int LOG_W     = 5,
  parameter int SL_W      = 3
) (
  input  logic [SIZE_W-1:0] size,
  output logic              ok,
  output logic [SL_W-1:0]   step_log,
  output logic [LOG_W:0]    run_len
);
  localparam int WORD_BITS = 1 << LOG_W;

  logic [SIZE_W:0] sum;
  logic [SIZE_W:0] blocks;
  logic [31:0]     blocks32;
  logic            fits;

  always_comb begin
    sum      = {1'b0, size} + (SIZE_W+1)'((1 << BLK_SHIFT) - 1);
    blocks   = sum >> BLK_SHIFT;
    blocks32 = 32'(blocks);
    fits     = blocks32 <= 32'(WORD_BITS);
    ok       = (size != '0) && fits;
    run_len  = fits ? blocks[LOG_W:0] : (LOG_W+1)'(WORD_BITS);
    step_log = SL_W'(LOG_W);
    for (int i = LOG_W; i >= 0; i--) begin
      if (blocks32 <= (32'd1 << i)) step_log = SL_W'(i);
    end
  end
endmodule

// File: rtl/blkmap_runmask.sv
// Builds a run of len ones starting at bit pos, truncated at the word edge.
module blkmap_runmask #(
  parameter int LOG_W = 5
) (
  input  logic [LOG_W-1:0]        pos,
  input  logic [LOG_W:0]          len,
  output logic [(1<<LOG_W)-1:0]   mask
);
  localparam int WORD_BITS = 1 << LOG_W;

  for (genvar b = 0; b < WORD_BITS; b++) begin : g_bit
    localparam logic [LOG_W:0] BI = (LOG_W+1)'(b);
    assign mask[b] = ({1'b0, pos} <= BI) && ((BI - {1'b0, pos}) < len);
  end
endmodule

// File: rtl/blkmap_store.sv
// Occupancy map: one register word per map word, set or clear under a mask.
module blkmap_store #(
  parameter int WORDS     = 2,
  parameter int WORD_BITS = 32,
  parameter int WSEL_W    = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              set_en,
  input  logic                              clr_en,
  input  logic [WSEL_W-1:0]                 sel,
  input  logic [WORD_BITS-1:0]              mask,
  output logic [WORDS-1:0][WORD_BITS-1:0]   map_q
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit_w;
    assign hit_w = (sel == WSEL_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[w] <= '0;
      end else if (hit_w && set_en) begin
        map_q[w] <= map_q[w] | mask;
      end else if (hit_w && clr_en) begin
        map_q[w] <= map_q[w] & ~mask;
      end
    end
  end
endmodule

// File: rtl/blkmap_alloc.sv
module blkmap_alloc
  import blkmap_pkg::*;
#(
  parameter int MEM_BYTES = 16384,
  parameter int MAP_WORDS = 2,
  parameter int WORD_BITS = 32,
  parameter int SIZE_W    = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    req_valid,
  input  logic                                    req_op,
  input  logic [SIZE_W-1:0]                       req_size,
  input  logic [$clog2(MEM_BYTES):0]              req_offset,
  output logic                                    busy,
  output logic                                    done,
  output logic [$clog2(MEM_BYTES):0]              result_offset
);
  localparam int TOTAL_BLKS  = MAP_WORDS * WORD_BITS;
  localparam int BLOCK_BYTES = MEM_BYTES / TOTAL_BLKS;
  localparam int BLK_SHIFT   = $clog2(BLOCK_BYTES);
  localparam int LOG_W       = $clog2(WORD_BITS);
  localparam int SL_W        = $clog2(LOG_W + 1);
  localparam int WSEL_W      = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
  localparam int OFS_W       = $clog2(MEM_BYTES) + 1;

  bm_state_e             state_q, state_d;
  logic                  op_q, op_d;
  logic                  ok_q, ok_d;
  logic [SL_W-1:0]       steplog_q, steplog_d;
  logic [LOG_W:0]        run_q, run_d;
  logic [WSEL_W-1:0]     word_q, word_d;
  logic [LOG_W-1:0]      pos_q, pos_d;
  logic                  inrng_q, inrng_d;
  logic                  done_q, done_d;
  logic [OFS_W-1:0]      res_q, res_d;

  logic                  sz_ok;
  logic [SL_W-1:0]       sz_steplog;
  logic [LOG_W:0]        sz_run;
  logic [WORD_BITS-1:0]  run_mask;
  logic [MAP_WORDS-1:0][WORD_BITS-1:0] map_q;
  logic                  set_en, clr_en;

  logic [OFS_W-1:0]      idx_in;
  logic [OFS_W-1:0]      word_in;
  logic [LOG_W:0]        step;
  logic [LOG_W:0]        nxt_pos;
  logic                  last_word;
  logic                  hit;
  logic [OFS_W-1:0]      cand_ofs;

  blkmap_sizer #(
    .SIZE_W(SIZE_W), .BLK_SHIFT(BLK_SHIFT), .LOG_W(LOG_W), .SL_W(SL_W)
  ) u_sizer (
    .size(req_size), .ok(sz_ok), .step_log(sz_steplog), .run_len(sz_run)
  );

  blkmap_runmask #(.LOG_W(LOG_W)) u_mask (
    .pos(pos_q), .len(run_q), .mask(run_mask)
  );

  blkmap_store #(
    .WORDS(MAP_WORDS), .WORD_BITS(WORD_BITS), .WSEL_W(WSEL_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
    .sel(word_q), .mask(run_mask), .map_q(map_q)
  );

  // Derived values for the decode and search steps
  always_comb begin
    idx_in    = req_offset >> BLK_SHIFT;
    word_in   = idx_in >> LOG_W;
    step      = (LOG_W+1)'(1) << steplog_q;
    nxt_pos   = {1'b0, pos_q} + step;
    last_word = (word_q == WSEL_W'(MAP_WORDS - 1));
    hit       = (map_q[word_q] & run_mask) == '0;
    cand_ofs  = OFS_W'({word_q, pos_q}) << BLK_SHIFT;
  end

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    ok_d      = ok_q;
    steplog_d = steplog_q;
    run_d     = run_q;
    word_d    = word_q;
    pos_d     = pos_q;
    inrng_d   = inrng_q;
    res_d     = res_q;
    done_d    = 1'b0;
    set_en    = 1'b0;
    clr_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d      = req_op;
          ok_d      = sz_ok;
          steplog_d = sz_steplog;
          run_d     = sz_run;
          state_d   = ST_WORK;
          if (req_op == OP_FREE) begin
            word_d  = word_in[WSEL_W-1:0];
            pos_d   = idx_in[LOG_W-1:0];
            inrng_d = word_in < OFS_W'(MAP_WORDS);
            res_d   = idx_in << BLK_SHIFT;
          end else begin
            word_d  = '0;
            pos_d   = '0;
            inrng_d = 1'b1;
          end
        end
      end
      ST_WORK: begin
        if (op_q == OP_FREE) begin
          clr_en  = inrng_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (!ok_q) begin
          res_d   = OFS_W'(MEM_BYTES);
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (hit) begin
          set_en  = 1'b1;
          res_d   = cand_ofs;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (nxt_pos[LOG_W]) begin
          if (last_word) begin
            res_d   = OFS_W'(MEM_BYTES);
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            word_d = word_q + 1'b1;
            pos_d  = '0;
          end
        end else begin
          pos_d = nxt_pos[LOG_W-1:0];
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_ALLOC;
      ok_q      <= 1'b0;
      steplog_q <= '0;
      run_q     <= '0;
      word_q    <= '0;
      pos_q     <= '0;
      inrng_q   <= 1'b0;
      done_q    <= 1'b0;
      res_q     <= '0;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      ok_q      <= ok_d;
      steplog_q <= steplog_d;
      run_q     <= run_d;
      word_q    <= word_d;
      pos_q     <= pos_d;
      inrng_q   <= inrng_d;
      done_q    <= done_d;
      res_q     <= res_d;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign result_offset = res_q;
endmodule

module blkmap_alloc_chk #(
  parameter int OFS_W     = 15,
  parameter int BLK_SHIFT = 8,
  parameter int MEM_BYTES = 16384
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [OFS_W-1:0] result_offset
);
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r6_result_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result_offset[BLK_SHIFT-1:0] == '0));

  a_r5_result_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result_offset <= OFS_W'(MEM_BYTES)));
endmodule

bind blkmap_alloc blkmap_alloc_chk #(
  .OFS_W(OFS_W), .BLK_SHIFT(BLK_SHIFT), .MEM_BYTES(MEM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .done(done), .result_offset(result_offset)
);

// File: tb/blkmap_alloc_test.sv
module blkmap_alloc_test;
  localparam int CLK_P = 10;
  localparam int FAILV = 16384;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_op;
  logic [15:0] req_size;
  logic [14:0] req_offset;
  logic        busy;
  logic        done;
  logic [14:0] result_offset;

  int checks;
  int errors;
  int mon_checks;
  int mon_errors;
  bit reported;

  int    exp_q[$];
  string tag_q[$];

  blkmap_alloc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_offset(req_offset), .busy(busy),
    .done(done), .result_offset(result_offset)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic check(input bit cond, input string tag, input int got, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic report;
    if (!reported) begin
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    end
  endtask

  // Monitor: pops the expected result for every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errors++;
        $display("FAIL R9 unexpected done: got %0d expected none", result_offset);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (int'(result_offset) != e) begin
          mon_errors++;
          $display("FAIL %s result: got %0d expected %0d", t, result_offset, e);
        end
      end
    end
  end

  // Driver: queue expectation, issue request, measure done latency
  task automatic run_req(input logic op, input int size, input int ofs,
                         input int exp_ofs, input int exp_lat, input string tag);
    int lat;
    exp_q.push_back(exp_ofs);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_op     = op;
    req_size   = 16'(size);
    req_offset = 15'(ofs);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(busy == 1'b1, {tag, " R9 busy after accept"}, int'(busy), 1);
    lat = 0;
    do begin
      @(posedge clk);
      #1;
      lat++;
    end while (!done && lat < 300);
    check(lat == exp_lat, {tag, " R10 latency"}, lat, exp_lat);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_size = '0; req_offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    check(done == 1'b0, "R1 done at reset", int'(done), 0);

    run_req(1'b0, 300, 0, 0, 2, "R1 R2 first alloc");
    run_req(1'b0, 256, 0, 512, 4, "R2 single block after two");
    run_req(1'b0, 513, 0, 1024, 3, "R3 step of four");
    run_req(1'b0, 1, 0, 768, 5, "R2 gap inside step");
    run_req(1'b0, 1, 0, 1792, 9, "R2 last block of step");
    run_req(1'b0, 8192, 0, 8192, 3, "R4 full word moves on");
    run_req(1'b0, 4096, 0, 4096, 3, "R3 R6 step of sixteen");
    run_req(1'b0, 4096, 0, FAILV, 5, "R4 R5 no aligned run");
    run_req(1'b0, 8193, 0, FAILV, 1, "R5 oversize");
    run_req(1'b0, 0, 0, FAILV, 1, "R5 zero size");
    run_req(1'b1, 300, 0, 0, 1, "R7 release");
    run_req(1'b0, 512, 0, 0, 2, "R7 reuse released");
    run_req(1'b1, 8192, 8192, 8192, 1, "R7 release word");
    run_req(1'b0, 4097, 0, 8192, 3, "R3 R4 thirty two step");
    run_req(1'b1, 1024, 13312, 13312, 1, "R8 release free blocks");
    run_req(1'b0, 4096, 0, FAILV, 5, "R8 map intact");

    fork
      run_req(1'b0, 1, 0, 2048, 10, "R9 alloc during busy pulse");
      begin
        repeat (4) @(negedge clk);
        req_valid  = 1'b1;
        req_op     = 1'b1;
        req_size   = 16'd16384;
        req_offset = 15'd0;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 ignored request left idle", int'(busy), 0);
    run_req(1'b0, 512, 0, 2560, 7, "R9 ignored release had no effect");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule